// File: doc/BRIEF.md
# Quad DAC Serial Command Interface

This block is the digital front end of a four-channel, 8-bit digital-to-analog converter. A host writes 12-bit commands over a three-wire serial link made of an active-low chip select, a serial clock and a data line. Each command carries a 2-bit channel address, a 2-bit control field and an 8-bit data byte. The block keeps an input (staging) register and an output register for each channel. The four output registers leave the block as 8-bit codes that feed the converter cores.

All serial inputs and the load strobe pass through two-flop synchronizers into a system clock that runs at least four times faster than the serial clock. Edges are detected in that domain. Every sampled bit is echoed on the serial output twelve serial clocks later, so several devices can be daisy-chained. The echo launches on the rising serial edge by default, or on the falling edge once a mode command selects it. A rising edge on the separate load strobe copies all four staging registers to the outputs at any time.

The framing state machine has three states. IDLE waits with chip select high. SHIFT collects bits while chip select is low. EXEC is a one-cycle decode state. The transitions are: IDLE to SHIFT when chip select falls; SHIFT to EXEC when chip select rises after at least 12 bits; SHIFT to IDLE when chip select rises after fewer than 12 bits; EXEC to IDLE unconditionally.

Top module: `quad_dac_serial_front`

## Requirements
- R1: After reset, all four output codes are 0x00, the serial output is 0, and the echo launches on the rising serial clock edge.
- R2: A command is 12 bits sent MSB first. Bits 11:10 are the address (00=A, 01=B, 10=C, 11=D), bits 9:8 are the control field, and bits 7:0 are the data.
- R3: Control 01 writes the data to the addressed staging register and leaves every output code unchanged.
- R4: Control 10 writes the data to the addressed staging register, then loads all four output codes from their staging registers, including the new value.
- R5: Control 00 changes no register. The echo still runs.
- R6: In a frame longer than 12 bits, only the last 12 bits are decoded. In a 16-bit frame, the first four bits are discarded.
- R7: A command sent as a 4-bit packet, a pause with chip select held low, and then an 8-bit packet gives the same result as one 12-bit word.
- R8: A frame with fewer than 12 bits is discarded without effect.
- R9: A command takes effect only after chip select rises. While chip select is high, the serial clock and data are ignored and the serial output holds its value.
- R10: In rising mode, after each rising serial clock edge the serial output shows the bit that was sampled 12 serial clocks earlier. That history carries across frames and starts at zero after reset.
- R11: Control 11 selects the echo mode from data bit 0: 0 selects falling mode, 1 selects rising mode. In falling mode the echoed bit appears after the falling serial edge, and the rising edge leaves the output unchanged.
- R12: A rising edge of the load strobe copies all four staging registers to the output codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_in | input | 1 | Serial chip select, active low |
| sclk_in | input | 1 | Serial clock |
| din_in | input | 1 | Serial data in, MSB first |
| ldac_in | input | 1 | Load strobe, rising edge transfers staging to outputs |
| dout | output | 1 | Serial echo output |
| code_a | output | 8 | Output code, channel A |
| code_b | output | 8 | Output code, channel B |
| code_c | output | 8 | Output code, channel C |
| code_d | output | 8 | Output code, channel D |

## Verification
A vector table walks 12-bit writes with each control code to different channels, a 16-bit frame with a junk nibble, and an 8-bit short frame. Comparing all four codes after each frame separates a staging-only write from a write that updates every channel, and a decoded frame from a discarded one. Directed tests then check the following:
- A frame split into 4 and 8 bits against one 12-bit word.
- Serial clock activity while chip select is high.
- Codes read just before and just after the chip-select rise.
- The 12-clock echo, checked bit by bit in both launch modes, to tell which edge moves the output.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
    localparam int CHAN    = 4;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = $clog2(CHAN);
    localparam int CTL_W   = 2;
    localparam int CMD_W   = ADDR_W + CTL_W + DATA_W;
    localparam int CNT_W   = $clog2(CMD_W + 1);

    typedef enum logic [CTL_W-1:0] {
        CTL_NOP      = 2'b00,
        CTL_LOAD     = 2'b01,
        CTL_LOAD_UPD = 2'b10,
        CTL_MODE     = 2'b11
    } ctl_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_EXEC  = 2'd2
    } frame_st_e;

    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } echo_edge_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        ctl_e              ctl;
        logic [DATA_W-1:0] data;
    } cmd_t;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int       W       = 4,
    parameter int       STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[s] <= RST_VAL;
                    else        chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/qdac_frame.sv
module qdac_frame
    import qdac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_s,
    input  logic             cs_fall,
    input  logic             sclk_rise,
    input  logic             din_s,
    output cmd_t             cmd,
    output logic             exec_pulse,
    output logic             echo_tap,
    output logic [CNT_W-1:0] bit_cnt
);
    frame_st_e        state, state_nx;
    logic [CMD_W-1:0] sr;
    logic             take_bit;

    assign take_bit = sclk_rise && !cs_s;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (!cs_s) state_nx = ST_SHIFT;
            ST_SHIFT: if (cs_s)  state_nx = (bit_cnt >= CNT_W'(CMD_W)) ? ST_EXEC : ST_IDLE;
            ST_EXEC:  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr      <= '0;
            bit_cnt <= '0;
        end else begin
            if (take_bit) sr <= {sr[CMD_W-2:0], din_s};
            if (cs_fall)
                bit_cnt <= take_bit ? CNT_W'(1) : '0;
            else if (take_bit && bit_cnt < CNT_W'(CMD_W))
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    always_comb begin
        exec_pulse = (state == ST_EXEC);
        cmd        = cmd_t'(sr);
        echo_tap   = sr[CMD_W-1];
    end
endmodule

// File: rtl/qdac_echo.sv
module qdac_echo
    import qdac_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs_s,
    input  logic sclk_rise,
    input  logic sclk_fall,
    input  logic tap,
    input  logic set_mode,
    input  logic mode_bit,
    output logic dout,
    output logic edge_fall
);
    echo_edge_e edge_sel;
    logic       pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_sel <= EDGE_RISE;
            pend     <= 1'b0;
            dout     <= 1'b0;
        end else begin
            if (set_mode) edge_sel <= mode_bit ? EDGE_RISE : EDGE_FALL;
            if (!cs_s && sclk_rise) begin
                pend <= tap;
                if (edge_sel == EDGE_RISE) dout <= tap;
            end
            if (!cs_s && sclk_fall && edge_sel == EDGE_FALL) dout <= pend;
        end
    end

    assign edge_fall = (edge_sel == EDGE_FALL);
endmodule

// File: rtl/qdac_bank.sv
module qdac_bank
    import qdac_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     exec_pulse,
    input  cmd_t                     cmd,
    input  logic                     ldac_rise,
    output logic [CHAN*DATA_W-1:0]   codes
);
    logic [DATA_W-1:0] stage_q [CHAN];
    logic [DATA_W-1:0] out_q   [CHAN];
    logic              wr_stage, upd_all;

    assign wr_stage = exec_pulse && (cmd.ctl == CTL_LOAD || cmd.ctl == CTL_LOAD_UPD);
    assign upd_all  = exec_pulse && (cmd.ctl == CTL_LOAD_UPD);

    generate
        for (genvar ch = 0; ch < CHAN; ch++) begin : g_ch
            logic hit;
            assign hit = (cmd.addr == ADDR_W'(ch));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[ch] <= '0;
                    out_q[ch]   <= '0;
                end else begin
                    if (wr_stage && hit) stage_q[ch] <= cmd.data;
                    if (upd_all)
                        out_q[ch] <= hit ? cmd.data : stage_q[ch];
                    else if (ldac_rise)
                        out_q[ch] <= stage_q[ch];
                end
            end

            assign codes[ch*DATA_W +: DATA_W] = out_q[ch];
        end
    endgenerate
endmodule

// File: rtl/quad_dac_serial_front.sv
module quad_dac_serial_front
    import qdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_in,
    input  logic              sclk_in,
    input  logic              din_in,
    input  logic              ldac_in,
    output logic              dout,
    output logic [DATA_W-1:0] code_a,
    output logic [DATA_W-1:0] code_b,
    output logic [DATA_W-1:0] code_c,
    output logic [DATA_W-1:0] code_d
);
    logic [3:0] sync_q;
    logic       cs_s, sclk_s, din_s, ldac_s;
    logic       cs_q, sclk_q, ldac_q;
    logic       cs_fall, sclk_rise, sclk_fall, ldac_rise;
    cmd_t       cmd;
    logic       exec_pulse, echo_tap, edge_fall, set_mode;
    logic [CNT_W-1:0] bit_cnt;
    logic [CHAN*DATA_W-1:0] codes;

    qdac_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({cs_n_in, sclk_in, din_in, ldac_in}),
        .q(sync_q)
    );
    assign {cs_s, sclk_s, din_s, ldac_s} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
            ldac_q <= 1'b0;
        end else begin
            cs_q   <= cs_s;
            sclk_q <= sclk_s;
            ldac_q <= ldac_s;
        end
    end

    assign cs_fall   = !cs_s && cs_q;
    assign sclk_rise = sclk_s && !sclk_q;
    assign sclk_fall = !sclk_s && sclk_q;
    assign ldac_rise = ldac_s && !ldac_q;

    qdac_frame u_frame (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .cs_fall(cs_fall),
        .sclk_rise(sclk_rise), .din_s(din_s), .cmd(cmd),
        .exec_pulse(exec_pulse), .echo_tap(echo_tap), .bit_cnt(bit_cnt)
    );

    assign set_mode = exec_pulse && (cmd.ctl == CTL_MODE);

    qdac_echo u_echo (
        .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_rise(sclk_rise),
        .sclk_fall(sclk_fall), .tap(echo_tap), .set_mode(set_mode),
        .mode_bit(cmd.data[0]), .dout(dout), .edge_fall(edge_fall)
    );

    qdac_bank u_bank (
        .clk(clk), .rst_n(rst_n), .exec_pulse(exec_pulse), .cmd(cmd),
        .ldac_rise(ldac_rise), .codes(codes)
    );

    assign code_a = codes[0*DATA_W +: DATA_W];
    assign code_b = codes[1*DATA_W +: DATA_W];
    assign code_c = codes[2*DATA_W +: DATA_W];
    assign code_d = codes[3*DATA_W +: DATA_W];
endmodule

// File: rtl/qdac_checker.sv
module qdac_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        cs_s,
    input logic        sclk_rise,
    input logic        ldac_rise,
    input logic        exec_pulse,
    input logic [3:0]  bit_cnt,
    input logic        echo_tap,
    input logic        edge_fall,
    input logic        dout,
    input logic [31:0] codes
);
    // R9: chip select high freezes the serial output
    assert_cs_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> $stable(dout));

    // R9: decode happens only with chip select high
    assert_exec_cs_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        exec_pulse |-> cs_s);

    // R8: no execution from a frame shorter than a command
    assert_exec_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exec_pulse |-> (bit_cnt >= 4'd12));

    // R3 and R5: codes move only on a decode or a load strobe
    assert_code_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(exec_pulse || ldac_rise) |=> $stable(codes));

    // R10: rising mode echoes the 12-bit-old tap on the rising edge
    assert_echo_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_fall && !cs_s && sclk_rise) |=> (dout == $past(echo_tap)));

    // R11: falling mode never moves the output on a rising edge
    assert_echo_fall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_fall && sclk_rise) |=> $stable(dout));
endmodule

bind quad_dac_serial_front qdac_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_rise(sclk_rise),
    .ldac_rise(ldac_rise), .exec_pulse(exec_pulse), .bit_cnt(bit_cnt),
    .echo_tap(echo_tap), .edge_fall(edge_fall), .dout(dout), .codes(codes)
);

// File: tb/quad_dac_serial_front_test.sv
module quad_dac_serial_front_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, cs_n, sclk, din, ldac;
    logic dout;
    logic [7:0] code_a, code_b, code_c, code_d;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [11:0] hist;
    logic exp_bit, pre_val, rise_val, fall_val;

    quad_dac_serial_front uut (
        .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n), .sclk_in(sclk),
        .din_in(din), .ldac_in(ldac), .dout(dout),
        .code_a(code_a), .code_b(code_b), .code_c(code_c), .code_d(code_d)
    );

    // {word[15:0], length[4:0], expected {a,b,c,d}}
    localparam logic [52:0] VEC [7] = '{
        {16'h0211, 5'd12, 32'h11000000},
        {16'h0522, 5'd12, 32'h11000000},
        {16'h0A33, 5'd12, 32'h11223300},
        {16'h0C44, 5'd12, 32'h11223300},
        {16'hFE55, 5'd16, 32'h11223355},
        {16'h00A7, 5'd8,  32'h11223355},
        {16'h0199, 5'd12, 32'h11223355}
    };

    function automatic string vec_tag(int i);
        case (i)
            0: return "R4 write A with update";
            1: return "R3 stage-only write B";
            2: return "R2 update from C";
            3: return "R5 no-op to D";
            4: return "R6 16-bit frame";
            5: return "R8 short frame";
            default: return "R3 stage-only write A";
        endcase
    endfunction

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] all_codes();
        return {code_a, code_b, code_c, code_d};
    endfunction

    task automatic send_bit(logic b);
        pre_val = dout;
        exp_bit = hist[11];
        hist    = {hist[10:0], b};
        din     = b;
        tick(4);
        sclk = 1'b1;
        tick(8);
        rise_val = dout;
        sclk = 1'b0;
        tick(6);
        fall_val = dout;
    endtask

    task automatic send_frame(logic [23:0] w, int len);
        cs_n = 1'b0;
        tick(4);
        for (int i = len - 1; i >= 0; i--) send_bit(w[i]);
        tick(2);
        cs_n = 1'b1;
        tick(10);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; din = 1'b0; ldac = 1'b0;
        hist = '0;
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: reset state
        check("R1 codes after reset", all_codes(), 32'h0);
        check("R1 dout after reset", {31'b0, dout}, 32'h0);

        // vector table: R2 R3 R4 R5 R6 R8
        for (int i = 0; i < 7; i++) begin
            send_frame({8'h00, VEC[i][52:37]}, int'(VEC[i][36:32]));
            check(vec_tag(i), all_codes(), VEC[i][31:0]);
        end

        // R12: load strobe copies staging registers
        ldac = 1'b1; tick(8); ldac = 1'b0; tick(8);
        check("R12 load strobe", all_codes(), 32'h99223355);

        // R7: 4-bit then 8-bit packet, chip select held low
        cs_n = 1'b0; tick(4);
        for (int i = 11; i >= 8; i--) send_bit(12'h666 >> i);
        tick(30);
        for (int i = 7; i >= 0; i--) send_bit(12'h666 >> i);
        tick(2); cs_n = 1'b1; tick(10);
        check("R7 split packets", all_codes(), 32'h99663355);

        // R10: rising-mode echo (default after reset, R1)
        cs_n = 1'b0; tick(4);
        for (int i = 23; i >= 0; i--) begin
            send_bit(24'h5A3C00 >> i);
            check("R10 rising echo", {31'b0, rise_val}, {31'b0, exp_bit});
        end
        tick(2); cs_n = 1'b1; tick(10);
        check("R5 no-op frame keeps codes", all_codes(), 32'h99663355);

        // R11: select falling mode (addr A, ctl 11, D0=0)
        send_frame(24'h000300, 12);
        check("R11 mode command keeps codes", all_codes(), 32'h99663355);
        cs_n = 1'b0; tick(4);
        for (int i = 23; i >= 0; i--) begin
            send_bit(24'h963C00 >> i);
            check("R11 falling mode rise holds", {31'b0, rise_val}, {31'b0, pre_val});
            check("R11 falling mode echo", {31'b0, fall_val}, {31'b0, exp_bit});
        end
        tick(2); cs_n = 1'b1; tick(10);

        // R11: back to rising mode (D0=1)
        send_frame(24'h000301, 12);
        cs_n = 1'b0; tick(4);
        for (int i = 11; i >= 0; i--) begin
            send_bit(12'hC00 >> i);
            check("R11 rising mode restored", {31'b0, rise_val}, {31'b0, exp_bit});
        end
        tick(2); cs_n = 1'b1; tick(10);

        // R9: activity while chip select is high is ignored
        begin
            logic hold_dout;
            hold_dout = dout;
            for (int i = 0; i < 12; i++) begin
                din = i[0]; tick(4); sclk = 1'b1; tick(8); sclk = 1'b0; tick(6);
            end
            check("R9 codes with CS high", all_codes(), 32'h99663355);
            check("R9 dout with CS high", {31'b0, dout}, {31'b0, hold_dout});
        end

        // R9: command waits for chip select rise (A, ctl 10, 0x77)
        cs_n = 1'b0; tick(4);
        for (int i = 11; i >= 0; i--) begin
            send_bit(12'h277 >> i);
            check("R10 echo after idle clocks", {31'b0, rise_val}, {31'b0, exp_bit});
        end
        tick(10);
        check("R9 no effect before CS rise", all_codes(), 32'h99663355);
        cs_n = 1'b1; tick(10);
        check("R9 effect after CS rise", all_codes(), 32'h77663355);

        // R1: reset mid-run clears everything
        rst_n = 1'b0; tick(3);
        rst_n = 1'b1; tick(5);
        hist = '0;
        check("R1 codes after second reset", all_codes(), 32'h0);
        check("R1 dout after second reset", {31'b0, dout}, 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule